// File: doc/BRIEF.md
# Sequential Binarized Fully Connected Layer

This block computes one fully connected layer of a binarized neural network. Its input is a vector of values that are each +1 or -1, stored one bit per element: bit 1 means +1 and bit 0 means -1. It multiplies that vector by a matrix of single-bit weights. The work runs over several clock cycles. Each cycle it consumes one input element, and every output neuron updates its running sum in that same cycle. A short control sequence first clears the sums, then accumulates, then finalizes. After the last step it pulses `done_o`.

A parameter fixes the output form for each instance. In the default mode each output is reduced to one bit: 1 means +1 and 0 means -1. This form can feed the next binarized layer directly. In raw mode each output is a saturated two's-complement sum. This suits a last classifier layer, where the largest score names the winning class. The caller supplies the input vector and the weights on ports. Both are captured when a start request is accepted, so the caller may change them while the layer is computing.

Top module: `fc_bin_layer`

## Requirements
- R1: After reset, `done_o` and `busy_o` are 0 and both `y_bin_o` and `y_raw_o` are all zero.
- R2: When a start is accepted, `x_i` and `w_i` are captured. Changes to either port after that edge have no effect on the result of that run.
- R3: Input bit `x_i[i]` stands for +1 when it is 1 and -1 when it is 0. Neuron j uses weight bit `w_i[i*N_OUT+j]`. A weight of 1 adds the input value to the sum and a weight of 0 subtracts it. The sum of neuron j is the total over all i.
- R4: A start is accepted when `start_i` is high on an edge while `busy_o` is low. `done_o` is then seen high exactly N_IN+2 clock edges later: one edge for the clear step, N_IN edges for accumulation and one edge for finalization.
- R5: `done_o` is high for exactly one cycle per run. `busy_o` is high from the edge that accepts a start until the finalize edge, and it is low while `done_o` is high.
- R6: With RAW_OUT=0, `y_bin_o[j]` is 1 when the sum of neuron j is greater than zero. It is 0 otherwise, and that includes a sum of exactly zero.
- R7: With RAW_OUT=1, lane j of `y_raw_o` (bits `j*OUT_W` upward, OUT_W bits wide) holds the sum of neuron j in two's complement. A sum above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is clamped to that limit.
- R8: A start request made while `busy_o` is high is ignored. It neither restarts nor lengthens the run in progress.
- R9: The outputs change only on the edge that raises `done_o` and otherwise hold their value. The output not used by the chosen mode always reads zero: `y_raw_o` when RAW_OUT=0 and `y_bin_o` when RAW_OUT=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a run; accepted only when idle |
| x_i | input | N_IN | Input vector, 1 = +1, 0 = -1 |
| w_i | input | N_IN*N_OUT | Weight bits, row i at bits i*N_OUT upward |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when results are updated |
| y_bin_o | output | N_OUT | Binarized outputs (RAW_OUT=0), else zero |
| y_raw_o | output | N_OUT*OUT_W | Saturated signed sums (RAW_OUT=1), else zero |

## Verification
The assertions check the following on every cycle: the one-cycle width of `done_o` and how it sits against `busy_o`, the exact distance from an accepted start to `done_o` (measured by a counter, so a start made while busy cannot shorten or stretch the run), and that the outputs hold between pulses. The bench covers what depends on the data. It checks the arithmetic of the sums, the treatment of a zero sum as -1, clamping at both ends of the raw range, and that input and weight changes made during a run are not used. To do this it sweeps every input pattern of a small binarized instance and a stepped set of patterns of a small raw instance, and compares each result against a dot product it computes itself.

// File: rtl/fc_bin_pkg.sv
`timescale 1ns/1ps
package fc_bin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_ACC   = 2'd2,
    ST_FIN   = 2'd3
  } fc_state_e;

  function automatic int sum_width(input int n_in);
    return $clog2(n_in + 1) + 1;
  endfunction
endpackage

// File: rtl/fc_bin_ctrl.sv
`timescale 1ns/1ps
module fc_bin_ctrl
  import fc_bin_pkg::*;
#(
  parameter int N_IN  = 128,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             clear_o,
  output logic             acc_o,
  output logic             fin_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_IN - 1);

  fc_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_CLEAR;
        ST_CLEAR: begin
          idx_q   <= '0;
          state_q <= ST_ACC;
        end
        ST_ACC: begin
          if (idx_q == LAST) state_q <= ST_FIN;
          else               idx_q   <= idx_q + 1'b1;
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign clear_o  = (state_q == ST_CLEAR);
  assign acc_o    = (state_q == ST_ACC);
  assign fin_o    = (state_q == ST_FIN);
  assign idx_o    = idx_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
endmodule

// File: rtl/fc_bin_acc.sv
`timescale 1ns/1ps
module fc_bin_acc #(
  parameter int SUM_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    en_i,
  input  logic                    x_bit_i,
  input  logic                    w_bit_i,
  output logic signed [SUM_W-1:0] sum_o
);
  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] step;

  // equal bits: +1 (add +1 or subtract -1); differing bits: -1
  assign step = (x_bit_i == w_bit_i) ? SUM_W'(1) : {SUM_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_q <= '0;
    else if (clear_i) sum_q <= '0;
    else if (en_i)    sum_q <= sum_q + step;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/fc_bin_final.sv
`timescale 1ns/1ps
module fc_bin_final #(
  parameter int SUM_W = 9,
  parameter int OUT_W = 8
) (
  input  logic signed [SUM_W-1:0] sum_i,
  output logic                    bit_o,
  output logic        [OUT_W-1:0] raw_o
);
  localparam int MAX_V = (1 << (OUT_W - 1)) - 1;
  localparam int MIN_V = -(1 << (OUT_W - 1));

  logic signed [31:0] s_ext;
  logic signed [31:0] s_sat;

  always_comb begin
    s_ext = 32'(sum_i);
    if (s_ext > MAX_V)      s_sat = MAX_V;
    else if (s_ext < MIN_V) s_sat = MIN_V;
    else                    s_sat = s_ext;
  end

  assign bit_o = (s_ext > 0);
  assign raw_o = s_sat[OUT_W-1:0];
endmodule

// File: rtl/fc_bin_layer.sv
`timescale 1ns/1ps
module fc_bin_layer #(
  parameter int N_IN    = 128,
  parameter int N_OUT   = 32,
  parameter int OUT_W   = 8,
  parameter bit RAW_OUT = 1'b0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [N_IN-1:0]        x_i,
  input  logic [N_IN*N_OUT-1:0]  w_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [N_OUT-1:0]       y_bin_o,
  output logic [N_OUT*OUT_W-1:0] y_raw_o
);
  localparam int SUM_W = fc_bin_pkg::sum_width(N_IN);
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic             accept, clear, acc, fin;
  logic [IDX_W-1:0] idx;

  fc_bin_ctrl #(.N_IN(N_IN)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .clear_o  (clear),
    .acc_o    (acc),
    .fin_o    (fin),
    .idx_o    (idx),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  logic [N_IN-1:0]  x_q;
  logic [N_OUT-1:0] w_row_q [N_IN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      for (int i = 0; i < N_IN; i++) w_row_q[i] <= '0;
    end else if (accept) begin
      x_q <= x_i;
      for (int i = 0; i < N_IN; i++) w_row_q[i] <= w_i[i*N_OUT +: N_OUT];
    end
  end

  logic             x_cur;
  logic [N_OUT-1:0] w_cur;
  assign x_cur = x_q[idx];
  assign w_cur = w_row_q[idx];

  logic [N_OUT-1:0]       fin_bit;
  logic [N_OUT*OUT_W-1:0] fin_raw;

  for (genvar j = 0; j < N_OUT; j++) begin : g_neuron
    logic signed [SUM_W-1:0] sum;

    fc_bin_acc #(.SUM_W(SUM_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .en_i    (acc),
      .x_bit_i (x_cur),
      .w_bit_i (w_cur[j]),
      .sum_o   (sum)
    );

    fc_bin_final #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_fin (
      .sum_i (sum),
      .bit_o (fin_bit[j]),
      .raw_o (fin_raw[j*OUT_W +: OUT_W])
    );
  end

  if (RAW_OUT) begin : g_raw
    logic [N_OUT*OUT_W-1:0] y_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  y_q <= '0;
      else if (fin) y_q <= fin_raw;
    end
    assign y_raw_o = y_q;
    assign y_bin_o = '0;
  end else begin : g_bin
    logic [N_OUT-1:0] y_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  y_q <= '0;
      else if (fin) y_q <= fin_bit;
    end
    assign y_bin_o = y_q;
    assign y_raw_o = '0;
  end
endmodule

// File: rtl/fc_bin_layer_chk.sv
`timescale 1ns/1ps
module fc_bin_layer_chk #(
  parameter int N_IN  = 128,
  parameter int N_OUT = 32,
  parameter int OUT_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [N_OUT-1:0]       y_bin_o,
  input logic [N_OUT*OUT_W-1:0] y_raw_o
);
  int unsigned run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_cnt <= 0;
    else if (start_i && !busy_o)  run_cnt <= 0;
    else if (busy_o)              run_cnt <= run_cnt + 1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done_o wider than one cycle"); // R5

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))) else $error("done_o vs busy_o"); // R5

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o) else $error("start not accepted"); // R4

  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (run_cnt == N_IN + 2)) else $error("run length wrong"); // R8

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(y_bin_o) && $stable(y_raw_o))) else $error("outputs moved"); // R9
endmodule

bind fc_bin_layer fc_bin_layer_chk #(
  .N_IN  (N_IN),
  .N_OUT (N_OUT),
  .OUT_W (OUT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .y_bin_o (y_bin_o),
  .y_raw_o (y_raw_o)
);

// File: tb/fc_bin_layer_tb.sv
`timescale 1ns/1ps
module fc_bin_layer_tb;
  localparam int BN_IN = 8,  BN_OUT = 4;
  localparam int RN_IN = 12, RN_OUT = 4, R_W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // binarized instance
  logic                   b_start = 1'b0;
  logic [BN_IN-1:0]       b_x = '0;
  logic [BN_IN*BN_OUT-1:0] b_w = '0;
  logic                   b_busy, b_done;
  logic [BN_OUT-1:0]      b_ybin;
  logic [BN_OUT*8-1:0]    b_yraw;

  fc_bin_layer #(.N_IN(BN_IN), .N_OUT(BN_OUT), .OUT_W(8), .RAW_OUT(1'b0)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(b_start), .x_i(b_x), .w_i(b_w),
    .busy_o(b_busy), .done_o(b_done), .y_bin_o(b_ybin), .y_raw_o(b_yraw));

  // raw instance
  logic                     r_start = 1'b0;
  logic [RN_IN-1:0]         r_x = '0;
  logic [RN_IN*RN_OUT-1:0]  r_w = '0;
  logic                     r_busy, r_done;
  logic [RN_OUT-1:0]        r_ybin;
  logic [RN_OUT*R_W-1:0]    r_yraw;

  fc_bin_layer #(.N_IN(RN_IN), .N_OUT(RN_OUT), .OUT_W(R_W), .RAW_OUT(1'b1)) u_dut_raw (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(r_start), .x_i(r_x), .w_i(r_w),
    .busy_o(r_busy), .done_o(r_done), .y_bin_o(r_ybin), .y_raw_o(r_yraw));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dot(input logic [15:0] x, input logic [63:0] w,
                             input int n_in, input int n_out, input int j);
    int s = 0;
    for (int i = 0; i < n_in; i++) s += (x[i] == w[i*n_out+j]) ? 1 : -1;
    return s;
  endfunction

  function automatic logic [BN_OUT-1:0] exp_bin(input logic [BN_IN-1:0] x, input logic [BN_IN*BN_OUT-1:0] w);
    logic [BN_OUT-1:0] r;
    for (int j = 0; j < BN_OUT; j++) r[j] = (dot(16'(x), 64'(w), BN_IN, BN_OUT, j) > 0);
    return r;
  endfunction

  function automatic logic [RN_OUT*R_W-1:0] exp_raw(input logic [RN_IN-1:0] x, input logic [RN_IN*RN_OUT-1:0] w);
    logic [RN_OUT*R_W-1:0] r;
    int s;
    for (int j = 0; j < RN_OUT; j++) begin
      s = dot(16'(x), 64'(w), RN_IN, RN_OUT, j);
      if (s > 7)  s = 7;
      if (s < -8) s = -8;
      r[j*R_W +: R_W] = 4'(s);
    end
    return r;
  endfunction

  task automatic run_bin(input logic [BN_IN-1:0] x, input logic [BN_IN*BN_OUT-1:0] w,
                         output logic [BN_OUT-1:0] y, output int cyc);
    @(negedge clk_i); b_x = x; b_w = w; b_start = 1'b1;
    @(posedge clk_i); @(negedge clk_i); b_start = 1'b0;
    cyc = 0;
    while (!b_done && cyc < 1000) begin @(posedge clk_i); @(negedge clk_i); cyc++; end
    y = b_ybin;
  endtask

  task automatic run_raw(input logic [RN_IN-1:0] x, input logic [RN_IN*RN_OUT-1:0] w,
                         output logic [RN_OUT*R_W-1:0] y, output int cyc);
    @(negedge clk_i); r_x = x; r_w = w; r_start = 1'b1;
    @(posedge clk_i); @(negedge clk_i); r_start = 1'b0;
    cyc = 0;
    while (!r_done && cyc < 1000) begin @(posedge clk_i); @(negedge clk_i); cyc++; end
    y = r_yraw;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [BN_IN*BN_OUT-1:0] bw [3];
    logic [BN_OUT-1:0]       yb;
    logic [RN_OUT*R_W-1:0]   yr;
    int cyc;

    bw[0] = 32'hA5C3_0F96;
    bw[1] = 32'hFFFF_0000;
    bw[2] = 32'h1234_FEDC;

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1: reset state
    check("R1", "b_done", b_done, 0);
    check("R1", "b_busy", b_busy, 0);
    check("R1", "b_ybin", b_ybin, 0);
    check("R1", "r_done", r_done, 0);
    check("R1", "r_yraw", r_yraw, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "b_busy after release", b_busy, 0);

    // R3 R6: every input pattern against three weight sets
    for (int k = 0; k < 3; k++) begin
      for (int x = 0; x < (1 << BN_IN); x++) begin
        run_bin(BN_IN'(x), bw[k], yb, cyc);
        check("R6", $sformatf("bin x=%0h k=%0d", x, k), yb, exp_bin(BN_IN'(x), bw[k]));
        if (x == 0) check("R4", "bin latency", cyc, BN_IN + 2);
      end
    end

    // R6: zero sum reads as -1 (bit 0); x=0F w row pattern gives sum 0 on every lane
    run_bin(8'h0F, {8{4'hF}}, yb, cyc);
    check("R6", "zero sum -> 0", yb, 0);
    run_bin(8'h1F, {8{4'hF}}, yb, cyc);
    check("R3", "sum +2 -> 1", yb, 4'hF);

    // R5: done is a single-cycle pulse, busy low with it
    run_bin(8'hC3, bw[0], yb, cyc);
    check("R5", "busy with done", b_busy, 0);
    @(posedge clk_i); @(negedge clk_i);
    check("R5", "done one cycle", b_done, 0);

    // R2 R8: change inputs and re-request start mid-run
    @(negedge clk_i); b_x = 8'h5A; b_w = bw[2]; b_start = 1'b1;
    @(posedge clk_i); @(negedge clk_i); b_start = 1'b0;
    check("R5", "busy after accept", b_busy, 1);
    cyc = 0;
    repeat (3) begin @(posedge clk_i); @(negedge clk_i); cyc++; end
    b_x = 8'hA5; b_w = bw[1]; b_start = 1'b1;
    @(posedge clk_i); @(negedge clk_i); cyc++;
    b_start = 1'b0;
    while (!b_done && cyc < 1000) begin @(posedge clk_i); @(negedge clk_i); cyc++; end
    check("R8", "latency with busy start", cyc, BN_IN + 2);
    check("R2", "latched result", b_ybin, exp_bin(8'h5A, bw[2]));
    yb = b_ybin;

    // R9: outputs hold while idle with inputs moving, unused output zero
    repeat (5) begin @(negedge clk_i); b_x = ~b_x; b_w = ~b_w; end
    check("R9", "bin hold", b_ybin, yb);
    check("R8", "no restart while idle without start", b_busy, 0);
    check("R9", "unused raw zero", b_yraw, 0);

    // R7: saturation at both ends and zero
    run_raw('1, '1, yr, cyc);
    check("R7", "sat high", yr, {RN_OUT{4'h7}});
    check("R4", "raw latency", cyc, RN_IN + 2);
    run_raw('0, '1, yr, cyc);
    check("R7", "sat low", yr, {RN_OUT{4'h8}});
    run_raw(12'h03F, '1, yr, cyc);
    check("R7", "zero sum", yr, 0);
    run_raw(12'h0FF, '1, yr, cyc);
    check("R7", "sum +4", yr, {RN_OUT{4'h4}});

    // R7 R3: stepped sweep with two weight sets
    for (int x = 0; x < (1 << RN_IN); x += 13) begin
      run_raw(RN_IN'(x), 48'hF0F0_3C3C_A5A5, yr, cyc);
      check("R7", $sformatf("raw x=%0h w0", x), yr, exp_raw(RN_IN'(x), 48'hF0F0_3C3C_A5A5));
      run_raw(RN_IN'(x), 48'h0123_4567_89AB, yr, cyc);
      check("R3", $sformatf("raw x=%0h w1", x), yr, exp_raw(RN_IN'(x), 48'h0123_4567_89AB));
    end
    check("R9", "unused bin zero", r_ybin, 0);

    summary();
  end
endmodule